// File: doc/BRIEF.md
# Multiplicative Frequency Boost Controller

This block keeps a boost term that a frequency governor adds to a load-derived target clock rate. An activity monitor upstream raises one of two single-cycle events: an upper-breach pulse when the averaged activity has stayed above its high watermark for the configured number of periods, and a lower-breach pulse when it has stayed below its low watermark. On an upper breach the boost is scaled up by a percentage coefficient, a fixed additive step is added, and the result is clamped to the maximum frequency. On a lower breach the boost is scaled down by a second coefficient, and it snaps to zero once it falls under half the step.

After every event the block decides whether each breach interrupt should stay armed. It stays armed only while further movement in that direction is still possible. An optional dependency threshold on the average count can force the lower-breach interrupt on, or switch it off. The block then computes a target frequency: the average count is converted to a rate over the sampling period and scaled by the inverse of the boost-up threshold, and the boost is added. The result can be raised to a floor frequency. The work runs sequentially through a small state machine. The states are IDLE, BOOST (apply the boost update and the arming decisions), SCALE (form the load-derived rate) and SUM (add the boost, apply the floor, raise done). Each state moves to the next on the following clock, and SUM returns to IDLE.

Top module: `boost_ctl`

## Requirements
- R1: After reset, boost and target are 0, both arm outputs are 1 and done is 0.
- R2: An upper-breach event sets boost to min(boost*up_pct/100 + 16000, fmax), using integer division.
- R3: After an upper-breach event, arm_dn is 1. arm_up is 1 only if the new boost is below fmax. arm_up is 0 only while boost equals fmax.
- R4: A lower-breach event sets boost to boost*dn_pct/100, using integer division. A result below 8000 becomes 0.
- R5: After a lower-breach event, arm_up is 1 and arm_dn is 1 only if the new boost is nonzero. This is subject to R6. arm_dn is 0 only while boost is 0.
- R6: When dep_thr is nonzero, an event with avg_cnt >= dep_thr leaves arm_dn at 1. An event with avg_cnt < dep_thr that leaves boost at 0 sets arm_dn to 0.
- R7: After each event, target = ((avg_cnt/12) * (10000/up_thr)) / 100 + boost, using integer divisions and saturating at all ones.
- R8: When dep_thr is nonzero and avg_cnt >= dep_thr, target is raised to at least floor_freq.
- R9: If up_evt and dn_evt are both high in the same accepted cycle, the event is handled as an upper breach.
- R10: done is a one-cycle pulse in the third clock cycle after the clock that accepts an event. Boost changes exactly two cycles before done.
- R11: Events that arrive while a computation is in progress, which is the three clocks after acceptance, are ignored and start no further computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_evt | input | 1 | Upper-breach event pulse |
| dn_evt | input | 1 | Lower-breach event pulse |
| avg_cnt | input | W | Averaged activity count, sampled when an event is accepted |
| fmax | input | W | Maximum frequency, the ceiling for boost |
| up_pct | input | PW | Growth coefficient in percent |
| dn_pct | input | PW | Decay coefficient in percent, at most 100 |
| up_thr | input | TW | Boost-up threshold in percent, nonzero |
| dep_thr | input | W | Dependency threshold on avg_cnt, 0 disables it |
| floor_freq | input | W | Minimum target while the dependency threshold is reached |
| boost | output | W | Current boost term |
| arm_up | output | 1 | Re-arm enable for the upper-breach interrupt |
| arm_dn | output | 1 | Re-arm enable for the lower-breach interrupt |
| target | output | W | Computed target frequency |
| done | output | 1 | One-cycle strobe when boost, arms and target are valid |

## Verification
The checker relies on fmax being held constant while the block runs. Under that assumption it checks that boost never exceeds fmax, that boost never sits between 0 and the half step unless it equals fmax, that each disarmed interrupt matches the boost value it implies, and that boost and done keep a fixed two-cycle spacing. The stimulus sets fmax once before reset is released. It changes coefficients and thresholds only while the block is idle, and it always keeps up_thr nonzero and dn_pct at or below 100.

// File: rtl/boost_ctl_pkg.sv
package boost_ctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BOOST = 2'd1,
        ST_SCALE = 2'd2,
        ST_SUM   = 2'd3
    } bc_state_t;
endpackage

// File: rtl/boost_step.sv
module boost_step #(
    parameter int W    = 32,
    parameter int PW   = 12,
    parameter int STEP = 16000
) (
    input  logic          is_up,
    input  logic [W-1:0]  boost_cur,
    input  logic [W-1:0]  fmax,
    input  logic [W-1:0]  avg,
    input  logic [W-1:0]  dep_thr,
    input  logic [PW-1:0] up_pct,
    input  logic [PW-1:0] dn_pct,
    output logic [W-1:0]  boost_nxt,
    output logic          arm_up_nxt,
    output logic          arm_dn_nxt
);
    localparam int XW = W + PW;
    localparam logic [XW:0]   STEP_X  = (XW+1)'(STEP);
    localparam logic [XW-1:0] HALF_X  = XW'(STEP / 2);
    localparam logic [XW-1:0] HUNDRED = XW'(100);

    logic [PW-1:0] pct;
    logic [XW-1:0] prod;
    logic [XW-1:0] scaled;
    logic [XW:0]   grown;
    logic [XW:0]   fmax_x;

    always_comb begin
        pct        = is_up ? up_pct : dn_pct;
        prod       = XW'(boost_cur) * XW'(pct);
        scaled     = prod / HUNDRED;
        grown      = {1'b0, scaled} + STEP_X;
        fmax_x     = (XW+1)'(fmax);
        boost_nxt  = boost_cur;
        arm_up_nxt = 1'b1;
        arm_dn_nxt = 1'b1;
        if (is_up) begin
            // growth: geometric plus step, clamped at the ceiling
            if (grown >= fmax_x) begin
                boost_nxt  = fmax;
                arm_up_nxt = 1'b0;
            end else begin
                boost_nxt  = grown[W-1:0];
            end
        end else begin
            // decay: geometric, snapped to zero under half a step
            if (scaled < HALF_X) begin
                boost_nxt  = '0;
                arm_dn_nxt = 1'b0;
            end else begin
                boost_nxt  = scaled[W-1:0];
            end
        end
        if (dep_thr != '0) begin
            if (avg >= dep_thr)
                arm_dn_nxt = 1'b1;
            else if (boost_nxt == '0)
                arm_dn_nxt = 1'b0;
        end
    end
endmodule

// File: rtl/target_scale.sv
module target_scale #(
    parameter int W      = 32,
    parameter int TW     = 8,
    parameter int PERIOD = 12,
    parameter int CW     = 14
) (
    input  logic [W-1:0]    avg,
    input  logic [TW-1:0]   up_thr,
    output logic [W+CW-1:0] base
);
    localparam int PXW = W + CW;
    localparam logic [CW-1:0]  SUSTAIN = CW'(10000);
    localparam logic [PXW-1:0] HUNDRED = PXW'(100);

    logic [W-1:0]   rate;
    logic [CW-1:0]  coef;
    logic [PXW-1:0] prod;

    always_comb begin
        rate = avg / W'(PERIOD);
        coef = SUSTAIN / CW'(up_thr);
        prod = PXW'(rate) * PXW'(coef);
        base = prod / HUNDRED;
    end
endmodule

// File: rtl/boost_ctl.sv
module boost_ctl #(
    parameter int W      = 32,
    parameter int PW     = 12,
    parameter int TW     = 8,
    parameter int STEP   = 16000,
    parameter int PERIOD = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_evt,
    input  logic          dn_evt,
    input  logic [W-1:0]  avg_cnt,
    input  logic [W-1:0]  fmax,
    input  logic [PW-1:0] up_pct,
    input  logic [PW-1:0] dn_pct,
    input  logic [TW-1:0] up_thr,
    input  logic [W-1:0]  dep_thr,
    input  logic [W-1:0]  floor_freq,
    output logic [W-1:0]  boost,
    output logic          arm_up,
    output logic          arm_dn,
    output logic [W-1:0]  target,
    output logic          done
);
    import boost_ctl_pkg::*;

    localparam int CW = 14;
    localparam int BW = W + CW;
    localparam int SW = BW + 1;

    bc_state_t state, state_nxt;

    logic          ev_up_q;
    logic [W-1:0]  avg_q;
    logic [BW-1:0] base_q;
    logic [W-1:0]  boost_calc;
    logic          arm_up_calc;
    logic          arm_dn_calc;
    logic [BW-1:0] base_calc;
    logic [SW-1:0] sum_full;
    logic [W-1:0]  tgt_calc;
    logic          floor_hit;

    boost_step #(.W(W), .PW(PW), .STEP(STEP)) u_step (
        .is_up      (ev_up_q),
        .boost_cur  (boost),
        .fmax       (fmax),
        .avg        (avg_q),
        .dep_thr    (dep_thr),
        .up_pct     (up_pct),
        .dn_pct     (dn_pct),
        .boost_nxt  (boost_calc),
        .arm_up_nxt (arm_up_calc),
        .arm_dn_nxt (arm_dn_calc)
    );

    target_scale #(.W(W), .TW(TW), .PERIOD(PERIOD), .CW(CW)) u_scale (
        .avg    (avg_q),
        .up_thr (up_thr),
        .base   (base_calc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (up_evt || dn_evt) state_nxt = ST_BOOST;
            ST_BOOST: state_nxt = ST_SCALE;
            ST_SCALE: state_nxt = ST_SUM;
            ST_SUM:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        sum_full  = SW'(base_q) + SW'(boost);
        floor_hit = (dep_thr != '0) && (avg_q >= dep_thr);
        if (floor_hit && (sum_full < SW'(floor_freq)))
            sum_full = SW'(floor_freq);
        if (sum_full[SW-1:W] != '0) tgt_calc = '1;
        else                        tgt_calc = sum_full[W-1:0];
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_up_q <= 1'b0;
            avg_q   <= '0;
            base_q  <= '0;
            boost   <= '0;
            arm_up  <= 1'b1;
            arm_dn  <= 1'b1;
            target  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (up_evt || dn_evt) begin
                        ev_up_q <= up_evt;
                        avg_q   <= avg_cnt;
                    end
                end
                ST_BOOST: begin
                    boost  <= boost_calc;
                    arm_up <= arm_up_calc;
                    arm_dn <= arm_dn_calc;
                end
                ST_SCALE: base_q <= base_calc;
                ST_SUM: begin
                    target <= tgt_calc;
                    done   <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/boost_ctl_chk.sv
module boost_ctl_chk #(
    parameter int W    = 32,
    parameter int STEP = 16000
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] fmax,
    input logic [W-1:0] boost,
    input logic         arm_up,
    input logic         arm_dn,
    input logic         done
);
    localparam logic [W-1:0] HALF = W'(STEP / 2);

    a_r2_boost_capped: assert property (@(posedge clk) disable iff (!rst_n)
        boost <= fmax);

    a_r4_no_small_boost: assert property (@(posedge clk) disable iff (!rst_n)
        (boost == '0) || (boost >= HALF) || (boost == fmax));

    a_r3_up_disarm_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_up |-> boost == fmax);

    a_r5_dn_disarm_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_dn |-> boost == '0);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_boost_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(boost) |-> ##2 done);
endmodule

bind boost_ctl boost_ctl_chk #(.W(W), .STEP(STEP)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .fmax   (fmax),
    .boost  (boost),
    .arm_up (arm_up),
    .arm_dn (arm_dn),
    .done   (done)
);

// File: tb/boost_ctl_bench.sv
module boost_ctl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_evt = 1'b0, dn_evt = 1'b0;
    logic [31:0] avg_cnt = '0, fmax = 32'd1000000;
    logic [11:0] up_pct = 12'd200, dn_pct = 12'd50;
    logic [7:0]  up_thr = 8'd60;
    logic [31:0] dep_thr = '0, floor_freq = '0;
    logic [31:0] boost, target;
    logic        arm_up, arm_dn, done;

    int checks = 0, fails = 0;
    longint e_boost = 0, e_tgt = 0;
    bit e_up = 1, e_dn = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    boost_ctl u_boost_ctl (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic model(input bit is_up);
        longint s;
        if (is_up) begin
            s = e_boost * longint'(up_pct) / 100 + 16000;
            if (s >= longint'(fmax)) begin e_boost = fmax; e_up = 0; end
            else begin e_boost = s; e_up = 1; end
            e_dn = 1;
        end else begin
            s = e_boost * longint'(dn_pct) / 100;
            e_up = 1;
            if (s < 8000) begin e_boost = 0; e_dn = 0; end
            else begin e_boost = s; e_dn = 1; end
        end
        if (dep_thr != 0) begin
            if (avg_cnt >= dep_thr) e_dn = 1;
            else if (e_boost == 0) e_dn = 0;
        end
        e_tgt = (longint'(avg_cnt) / 12) * (10000 / longint'(up_thr)) / 100 + e_boost;
        if (dep_thr != 0 && avg_cnt >= dep_thr && e_tgt < longint'(floor_freq)) e_tgt = floor_freq;
        if (e_tgt > 64'hFFFF_FFFF) e_tgt = 64'hFFFF_FFFF;
    endtask

    // pulse one event, optionally a second one while busy; check all outputs
    task automatic run_event(input bit u, input bit d, input bit busy_extra, input string tag);
        int cnt = 0;
        model(u);
        @(negedge clk); up_evt = u; dn_evt = d;
        @(negedge clk); up_evt = 0; dn_evt = 0; cnt = 1;
        if (busy_extra) begin dn_evt = 1; up_evt = 1; end
        while (!done && cnt < 20) begin
            @(negedge clk); cnt++;
            up_evt = 0; dn_evt = 0;
        end
        chk(cnt == 4, {tag, " R10 done latency"}, cnt, 4);
        chk(longint'(boost) == e_boost, {tag, " R2/R4 boost"}, boost, e_boost);
        chk(arm_up == e_up, {tag, " R3/R5 arm_up"}, arm_up, e_up);
        chk(arm_dn == e_dn, {tag, " R5/R6 arm_dn"}, arm_dn, e_dn);
        chk(longint'(target) == e_tgt, {tag, " R7/R8 target"}, target, e_tgt);
        @(negedge clk);
        chk(done == 0, {tag, " R10 done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        chk(boost == 0, "R1 boost", boost, 0);
        chk(target == 0, "R1 target", target, 0);
        chk(arm_up && arm_dn, "R1 arms", {arm_up, arm_dn}, 3);
        chk(done == 0, "R1 done", done, 0);
    endtask

    task automatic t_up_ramp();
        avg_cnt = 120000;
        for (int i = 0; i < 6; i++) run_event(1, 0, 0, "R2 ramp");
        chk(boost == fmax && !arm_up, "R3 saturated", boost, fmax);
    endtask

    task automatic t_down_decay();
        while (e_boost != 0) run_event(0, 1, 0, "R4 decay");
        chk(boost == 0 && !arm_dn, "R5 snapped", boost, 0);
    endtask

    task automatic t_priority();
        run_event(1, 1, 0, "R9 both");
        chk(boost == 16000, "R9 up wins", boost, 16000);
    endtask

    task automatic t_busy();
        run_event(1, 0, 1, "R11 busy");
        repeat (6) begin
            @(negedge clk);
            chk(done == 0 && longint'(boost) == e_boost, "R11 no extra run", boost, e_boost);
        end
    endtask

    task automatic t_dependency();
        @(negedge clk);
        up_pct = 800; dn_pct = 90; up_thr = 27; dep_thr = 50000; floor_freq = 300000;
        avg_cnt = 40000;
        while (e_boost != 0) run_event(0, 1, 0, "R6 decay");
        run_event(0, 1, 0, "R6 below thr");
        chk(arm_dn == 0, "R6 disabled", arm_dn, 0);
        avg_cnt = 600000;
        run_event(0, 1, 0, "R6 at thr");
        chk(arm_dn == 1, "R6 forced on", arm_dn, 1);
        chk(target == 300000, "R8 floor", target, 300000);
        run_event(1, 0, 0, "R8 up floor");
        avg_cnt = 1200000;
        run_event(1, 0, 0, "R7 above floor");
        chk(target == 514000, "R7 value", target, 514000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up_ramp();
        t_down_decay();
        t_priority();
        t_busy();
        t_dependency();
        summary();
    end
endmodule